// File: doc/BRIEF.md
# SPI Peripheral with Status Flags

This block is a byte-wide SPI shift engine with a small CPU-side register set. Software picks master or slave operation, clock polarity and phase, and one of four master clock rates through a control register. It loads the byte to send through a data register, and reads the received byte back from the same address. In master mode, a data write while idle starts an eight-bit, MSB-first transfer. The block then drives SCK at the selected rate from the system clock. In slave mode, the engine follows an external SCK that is qualified by a low slave-select input.

Three sticky flags report the engine's condition in a status register: a completed transfer, a data write that landed while a transfer was running, and a mode fault. A mode fault is slave-select pulled low while the block is an enabled master. None of the flags can be cleared by writing them. Each one needs a status read taken while it is set, followed by an access to a specific register. Until the completion flag has gone through that sequence, further data writes are dropped. A mode fault also switches the block off and back to slave operation. The interrupt request combines the completion and fault flags under an enable bit.

Top module: `spi_unit_top`

## Requirements
- R1: After reset, the control (address 0), status (address 1) and data (address 2) registers read 0x00, the interrupt request is low and SCK is low. Address 3 always reads 0x00. Control layout: bit 6 interrupt enable, bit 5 enable, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate; bit 7 reads 0.
- R2: In master mode (enable and master bits set), a data write while idle starts a transfer of 8 bits, MSB first, with 8 SCK pulses. At the end, status bit 7 (complete) sets and a data read returns the byte shifted in on the serial input.
- R3: In master mode, SCK spends 1, 2, 8 or 16 system clocks in each half period for rate codes 0, 1, 2 and 3. This is a division of the system clock by 2, 4, 16 or 32.
- R4: While no transfer runs, SCK rests at the polarity bit. The phase bit selects whether data is sampled on the leading edge (phase 0) or the trailing edge (phase 1) of each SCK pulse.
- R5: In slave mode with phase 0, the first bit appears on the serial output as soon as slave-select is low. The input is sampled on leading edges. The complete flag sets after the eighth pulse.
- R6: In slave mode with phase 1, the output changes on leading edges and the input is sampled on trailing edges. The complete flag sets on the eighth trailing edge.
- R7: Status bit 7 clears only after a status read taken while it is set, followed by a data-register read or write. A data access with no such prior read leaves it set.
- R8: While status bit 7 is set and no status read has yet been taken with it set, data writes are ignored: no transfer starts and the transmit byte is not replaced.
- R9: A data write while a transfer is running sets status bit 6 (collision) and does not alter the running transfer. Bit 6 clears through the same status-read-then-data-access sequence.
- R10: An enabled master whose slave-select input goes low sets status bit 4 (mode fault), clears the enable and master bits, and aborts any transfer without setting bit 7.
- R11: Status bit 4 clears only after a status read taken while it is set, followed by a control-register write. A control write with no such prior read leaves it set.
- R12: The interrupt request is high exactly when the interrupt enable bit is set and status bit 7 or bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | One-cycle register read strobe |
| cpu_wr | input | 1 | One-cycle register write strobe |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| ss_n_i | input | 1 | Active-low slave select / fault sense |
| sdi | input | 1 | Serial data in (peer's output) |
| sdo | output | 1 | Serial data out |

## Verification
The bench uses the default parameters: two synchronizer stages on the external SCK and slave-select, and a largest half period of sixteen system clocks. This lets one run cover all four rate codes, from single-cycle SCK phases to the slowest setting. The two-stage synchronizer makes slave-side edges land three system clocks after the pin changes. The bench therefore spaces its externally driven SCK edges eight system clocks apart, which leaves both phase modes settled at every bit it samples. Master transfers loop the serial output back to the input, so each received byte must equal the byte sent.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int REG_W    = 8;
    localparam int ADDR_W   = 2;
    localparam int MAX_HALF = 16;

    localparam int ST_DONE_BIT  = 7;
    localparam int ST_COLL_BIT  = 6;
    localparam int ST_FAULT_BIT = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    typedef struct packed {
        logic       irq_en;
        logic       en;
        logic       mstr;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    // System clocks per SCK half period for each rate code
    function automatic logic [4:0] half_period(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd2;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        return {1'b0, c.irq_en, c.en, c.mstr, c.cpol, c.cpha, c.rate};
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] b);
        ctrl_t c;
        c.irq_en = b[6];
        c.en     = b[5];
        c.mstr   = b[4];
        c.cpol   = b[3];
        c.cpha   = b[2];
        c.rate   = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               W       = 2,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [W-1:0] q [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) q[i] <= RST_VAL;
                end else begin
                    q[0] <= din;
                    for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
                end
            end
            assign dout = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_pkg::*;
#(
    parameter int MAX_HALF_P = MAX_HALF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int CW = $clog2(MAX_HALF_P + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = CW'(half_period(rate) - 5'd1);

    always_ff @(posedge clk) begin
        if (rst || !run)        cnt <= '0;
        else if (cnt >= limit)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= limit);

endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_pkg::*;
#(
    parameter int DW         = REG_W,
    parameter int MAX_HALF_P = MAX_HALF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          mstr,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [1:0]    rate,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sck_s,
    input  logic          ss_n_s,
    input  logic          sdi,
    output logic          sck_o,
    output logic          sdo,
    output logic          busy,
    output logic          xfer_done,
    output logic [DW-1:0] rx_data
);

    localparam int EW     = $clog2(2 * DW);
    localparam int LAST_E = 2 * DW - 1;

    logic          active;
    logic [EW-1:0] edge_cnt;
    logic [DW-1:0] txsh;
    logic [DW-1:0] rxsh;
    logic          sck_q;
    logic          sck_prev;
    logic          mtick;
    logic          sedge;
    logic          edge_ev;
    logic          last_edge;
    logic          is_lead;
    logic          shift_tx;
    logic          sample_rx;
    logic          cnt_clear;

    spi_rate_gen #(.MAX_HALF_P(MAX_HALF_P)) u_rate (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .rate (rate),
        .tick (mtick)
    );

    assign sedge     = en && !mstr && !ss_n_s && (sck_s != sck_prev);
    assign edge_ev   = mstr ? mtick : sedge;
    assign last_edge = (edge_cnt == EW'(LAST_E));
    assign is_lead   = !edge_cnt[0];
    assign shift_tx  = cpha ? (is_lead && (edge_cnt != '0)) : !is_lead;
    assign sample_rx = cpha ? !is_lead : is_lead;
    assign xfer_done = en && edge_ev && last_edge;
    assign cnt_clear = !en || (mstr ? !active : ss_n_s);

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !en || !mstr) active <= 1'b0;
        else if (load)           active <= 1'b1;
        else if (xfer_done)      active <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_clear)  edge_cnt <= '0;
        else if (edge_ev)      edge_cnt <= last_edge ? '0 : edge_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                       txsh <= '0;
        else if (load)                 txsh <= load_data;
        else if (edge_ev && shift_tx)  txsh <= {txsh[DW-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)                        rxsh <= '0;
        else if (edge_ev && sample_rx)  rxsh <= {rxsh[DW-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (rst)            rx_data <= '0;
        else if (xfer_done) rx_data <= sample_rx ? {rxsh[DW-2:0], sdi} : rxsh;
    end

    always_ff @(posedge clk) begin
        if (rst)          sck_q <= 1'b0;
        else if (!active) sck_q <= cpol;
        else if (mtick)   sck_q <= ~sck_q;
    end

    assign sck_o = sck_q;
    assign sdo   = txsh[DW-1];
    assign busy  = en && (mstr ? active : (!ss_n_s && (!cpha || (edge_cnt != '0))));

    // R2
    xfer_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (active && xfer_done) |=> !active);

    // R4
    sck_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (sck_q == $past(cpol)));

endmodule

// File: rtl/spi_csr.sv
module spi_csr
    import spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output ctrl_t             ctrl,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [REG_W-1:0]  rx_data,
    input  logic              ss_n_s,
    output logic              load,
    output logic [REG_W-1:0]  load_data,
    output logic              irq
);

    addr_e a;
    logic  rd_stat, data_acc, wr_data, wr_ctrl;
    logic  fault_now, blocked;
    logic  done_f, done_arm;
    logic  wcol_f, wcol_arm;
    logic  fault_f, fault_arm;
    logic [REG_W-1:0] stat_word;

    assign a         = addr_e'(cpu_addr);
    assign rd_stat   = cpu_rd && (a == ADDR_STAT);
    assign data_acc  = (cpu_rd || cpu_wr) && (a == ADDR_DATA);
    assign wr_data   = cpu_wr && (a == ADDR_DATA);
    assign wr_ctrl   = cpu_wr && (a == ADDR_CTRL);
    assign fault_now = ctrl.en && ctrl.mstr && !ss_n_s;
    assign blocked   = done_f && !done_arm;
    assign load      = wr_data && !blocked && !busy;
    assign load_data = cpu_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_f    <= 1'b0;
            done_arm  <= 1'b0;
            wcol_f    <= 1'b0;
            wcol_arm  <= 1'b0;
            fault_f   <= 1'b0;
            fault_arm <= 1'b0;
        end else begin
            if (xfer_done)                  done_f <= 1'b1;
            else if (data_acc && done_arm)  done_f <= 1'b0;
            if (data_acc && done_arm)       done_arm <= 1'b0;
            else if (rd_stat && done_f)     done_arm <= 1'b1;

            if (wr_data && busy)            wcol_f <= 1'b1;
            else if (data_acc && wcol_arm)  wcol_f <= 1'b0;
            if (data_acc && wcol_arm)       wcol_arm <= 1'b0;
            else if (rd_stat && wcol_f)     wcol_arm <= 1'b1;

            if (fault_now)                  fault_f <= 1'b1;
            else if (wr_ctrl && fault_arm)  fault_f <= 1'b0;
            if (wr_ctrl && fault_arm)       fault_arm <= 1'b0;
            else if (rd_stat && fault_f)    fault_arm <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (fault_now) begin
            ctrl.en   <= 1'b0;
            ctrl.mstr <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_unpack(cpu_wdata);
        end
    end

    always_comb begin
        stat_word               = '0;
        stat_word[ST_DONE_BIT]  = done_f;
        stat_word[ST_COLL_BIT]  = wcol_f;
        stat_word[ST_FAULT_BIT] = fault_f;
    end

    always_comb begin
        case (a)
            ADDR_CTRL: cpu_rdata = ctrl_pack(ctrl);
            ADDR_STAT: cpu_rdata = stat_word;
            ADDR_DATA: cpu_rdata = rx_data;
            default:   cpu_rdata = '0;
        endcase
    end

    assign irq = ctrl.irq_en && (done_f || fault_f);

    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_f) |-> $past(xfer_done));

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_f) |-> $past(data_acc && done_arm));

    // R7
    done_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_arm) |-> $past(rd_stat));

    // R8
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && done_f && !done_arm && !busy) |=> !busy);

    // R9
    wcol_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wcol_f) |-> $past(wr_data && busy));

    // R10
    fault_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_f) |-> (!ctrl.en && !ctrl.mstr));

    // R11
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_f) |-> $past(wr_ctrl && fault_arm));

endmodule

// File: rtl/spi_unit_top.sv
module spi_unit_top
    import spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_HALF_P  = MAX_HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    input  logic              ss_n_i,
    input  logic              sdi,
    output logic              sdo
);

    ctrl_t            ctrl;
    logic [1:0]       pins_s;
    logic             sck_s, ss_n_s;
    logic             busy, xfer_done, load;
    logic [REG_W-1:0] load_data, rx_data;

    spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ss_n_i, sck_i}),
        .dout (pins_s)
    );

    assign ss_n_s = pins_s[1];
    assign sck_s  = pins_s[0];

    spi_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .ctrl      (ctrl),
        .busy      (busy),
        .xfer_done (xfer_done),
        .rx_data   (rx_data),
        .ss_n_s    (ss_n_s),
        .load      (load),
        .load_data (load_data),
        .irq       (irq)
    );

    spi_engine #(.DW(REG_W), .MAX_HALF_P(MAX_HALF_P)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .mstr      (ctrl.mstr),
        .cpol      (ctrl.cpol),
        .cpha      (ctrl.cpha),
        .rate      (ctrl.rate),
        .load      (load),
        .load_data (load_data),
        .sck_s     (sck_s),
        .ss_n_s    (ss_n_s),
        .sdi       (sdi),
        .sck_o     (sck_o),
        .sdo       (sdo),
        .busy      (busy),
        .xfer_done (xfer_done),
        .rx_data   (rx_data)
    );

endmodule

// File: tb/test_spi_unit_top.sv
module test_spi_unit_top;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam int         HB     = 8;

    // {rate[1:0], cpol, cpha, tx[7:0], expected half period[4:0]}
    localparam logic [16:0] MVEC [6] = '{
        {2'd0, 1'b0, 1'b0, 8'hA5, 5'd1},
        {2'd1, 1'b0, 1'b1, 8'h3C, 5'd2},
        {2'd2, 1'b1, 1'b0, 8'h96, 5'd8},
        {2'd3, 1'b1, 1'b1, 8'hC3, 5'd16},
        {2'd0, 1'b1, 1'b1, 8'h01, 5'd1},
        {2'd1, 1'b1, 1'b0, 8'h80, 5'd2}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_rd, cpu_wr;
    logic [1:0] cpu_addr;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic       irq, sck_i, sck_o, ss_n_i, sdi, sdo;
    logic       loop_en, sdi_drv;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign sdi = loop_en ? sdo : sdi_drv;

    spi_unit_top i_spi_unit_top (
        .clk       (clk),
        .rst       (rst),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .irq       (irq),
        .sck_i     (sck_i),
        .sck_o     (sck_o),
        .ss_n_i    (ss_n_i),
        .sdi       (sdi),
        .sdo       (sdo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic measure(input logic pol, output int pulses, output int mn, output int mx);
        int run;
        logic [7:0] s;
        run = 0; pulses = 0; mn = 1000; mx = 0;
        for (int c = 0; c < 3000; c++) begin
            peek(A_STAT, s);
            if (sck_o != pol) run++;
            else if (run > 0) begin
                pulses++;
                if (run < mn) mn = run;
                if (run > mx) mx = run;
                run = 0;
            end
            if (s[7]) break;
        end
    endtask

    task automatic slave_xfer(input logic pha, input logic pol, input logic [7:0] mbyte,
                              output logic [7:0] sbyte);
        @(negedge clk);
        sck_i = pol; ss_n_i = 1'b0;
        repeat (HB) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin
            if (!pha) begin
                sdi_drv = mbyte[b]; sbyte[b] = sdo;
                repeat (HB) @(negedge clk);
                sck_i = ~pol;
                repeat (HB) @(negedge clk);
                sck_i = pol;
                repeat (HB) @(negedge clk);
            end else begin
                sck_i = ~pol;
                repeat (HB) @(negedge clk);
                sdi_drv = mbyte[b]; sbyte[b] = sdo;
                repeat (HB) @(negedge clk);
                sck_i = pol;
                repeat (HB) @(negedge clk);
            end
        end
        ss_n_i = 1'b1;
        repeat (HB) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] s, d, got;
        int pulses, mn, mx;
        logic ok;
        rst = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = 2'd0; cpu_wdata = 8'h00;
        sck_i = 1'b0; ss_n_i = 1'b1; sdi_drv = 1'b0; loop_en = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(A_CTRL, d);   chk("R1 ctrl", d, 8'h00);
        peek(A_STAT, d);   chk("R1 status", d, 8'h00);
        peek(A_DATA, d);   chk("R1 data", d, 8'h00);
        peek(2'd3, d);     chk("R1 unused addr", d, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 sck", sck_o, 1'b0);

        // Master vector walk: R2, R3, R4, R7
        for (int i = 0; i < 6; i++) begin
            logic [16:0] v;
            v = MVEC[i];
            cpu_write(A_CTRL, {3'b011, v[14], v[13], v[16:15]});
            repeat (3) @(negedge clk);
            chk("R4 idle level", sck_o, v[14]);
            cpu_write(A_DATA, v[12:5]);
            measure(v[14], pulses, mn, mx);
            chk("R2 pulse count", pulses, 8);
            chk("R3 min half period", mn, v[4:0]);
            chk("R3 max half period", mx, v[4:0]);
            chk("R4 idle after transfer", sck_o, v[14]);
            cpu_read(A_STAT, s);   chk("R2 complete flag", s, 8'h80);
            cpu_read(A_DATA, d);   chk("R2 received byte", d, v[12:5]);
            peek(A_STAT, s);       chk("R7 cleared by sequence", s, 8'h00);
        end

        // R7 / R8: data access without prior status read
        cpu_write(A_CTRL, 8'h31);
        cpu_write(A_DATA, 8'h77);
        measure(1'b0, pulses, mn, mx);
        cpu_read(A_DATA, d);
        peek(A_STAT, s);   chk("R7 data read alone keeps flag", s, 8'h80);
        chk("R12 irq gated by enable", irq, 1'b0);
        cpu_write(A_DATA, 8'h55);
        ok = 1'b1;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (sck_o != 1'b0) ok = 1'b0;
        end
        chk("R8 blocked write no clock", ok, 1'b1);
        peek(A_STAT, s);   chk("R8 flag unchanged", s, 8'h80);
        cpu_read(A_STAT, s);
        cpu_write(A_DATA, 8'h5A);
        peek(A_STAT, s);   chk("R7 write after read clears", s, 8'h00);
        measure(1'b0, pulses, mn, mx);
        cpu_read(A_STAT, s);
        cpu_read(A_DATA, d);   chk("R8 later byte sent", d, 8'h5A);

        // R9 write collision
        cpu_write(A_DATA, 8'h11);
        repeat (3) @(negedge clk);
        cpu_write(A_DATA, 8'h22);
        peek(A_STAT, s);   chk("R9 collision flag", s, 8'h40);
        measure(1'b0, pulses, mn, mx);
        cpu_read(A_STAT, s);   chk("R9 both flags", s, 8'hC0);
        cpu_read(A_DATA, d);   chk("R9 transfer unaltered", d, 8'h11);
        peek(A_STAT, s);       chk("R9 collision cleared", s, 8'h00);

        // R12 interrupt from completion
        cpu_write(A_CTRL, 8'h70);
        cpu_write(A_DATA, 8'h69);
        measure(1'b0, pulses, mn, mx);
        @(negedge clk);
        chk("R12 irq on complete", irq, 1'b1);
        cpu_read(A_STAT, s);
        cpu_read(A_DATA, d);
        @(negedge clk);
        chk("R12 irq drops", irq, 1'b0);

        // R10 / R11 mode fault
        cpu_write(A_CTRL, 8'h33);
        cpu_write(A_DATA, 8'hF0);
        repeat (20) @(negedge clk);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 clock released", sck_o, 1'b0);
        peek(A_STAT, s);   chk("R10 fault flag", s, 8'h10);
        peek(A_CTRL, d);   chk("R10 enable and master cleared", d, 8'h03);
        chk("R12 no irq when disabled", irq, 1'b0);
        ss_n_i = 1'b1;
        repeat (300) @(negedge clk);
        peek(A_STAT, s);   chk("R10 aborted no complete", s, 8'h10);
        cpu_write(A_CTRL, 8'h40);
        peek(A_STAT, s);   chk("R11 control write alone keeps fault", s, 8'h10);
        chk("R12 irq on fault", irq, 1'b1);
        cpu_read(A_STAT, s);
        cpu_write(A_CTRL, 8'h40);
        peek(A_STAT, s);   chk("R11 fault cleared", s, 8'h00);
        chk("R12 irq cleared", irq, 1'b0);

        // R5 slave, phase 0, polarity 0
        loop_en = 1'b0;
        sck_i = 1'b0;
        cpu_write(A_CTRL, 8'h20);
        cpu_write(A_DATA, 8'h2D);
        slave_xfer(1'b0, 1'b0, 8'hB4, got);
        chk("R5 slave output", got, 8'h2D);
        cpu_read(A_STAT, s);   chk("R5 complete", s, 8'h80);
        cpu_read(A_DATA, d);   chk("R5 slave input", d, 8'hB4);

        // R6 slave, phase 1, polarity 1
        sck_i = 1'b1;
        cpu_write(A_CTRL, 8'h2C);
        repeat (4) @(negedge clk);
        cpu_write(A_DATA, 8'hE1);
        slave_xfer(1'b1, 1'b1, 8'h4E, got);
        chk("R6 slave output", got, 8'hE1);
        cpu_read(A_STAT, s);   chk("R6 complete", s, 8'h80);
        cpu_read(A_DATA, d);   chk("R6 slave input", d, 8'h4E);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule